// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO

This block is a first-in first-out buffer for 9-bit words that joins two clock domains. Words enter on the write clock and leave on the read clock. The two clocks run freely and may be unrelated or identical. Each side has its own ready flag, and that flag changes only on its own clock. The write and read positions cross between the domains as Gray codes through two-stage synchronizers. A flag may therefore release a cycle or two late, but it never reports space or data that does not exist.

The read side has fall-through behaviour. The oldest stored word moves into the output register without any request, and `outReady` then shows that `rdData` holds a valid word. A read only consumes that word and lets the next one move up. A read needs both read enables and the output-enable qualifier.

Two status flags come from the write clock domain. The first reports more than half full. The second is a combined almost-full/almost-empty flag whose threshold can be loaded through the write port while the program-enable input is high. An asynchronous active-low reset clears the block. It must be held for at least four edges of each clock.

Top module: `fallthru_fifo`

## Requirements
- R1: Words come out on `rdData` bit for bit as they were written (not inverted), in the order they were written.
- R2: A word is stored on a rising `wrClk` edge only when `wrEnA`, `wrEnB` and `inReady` are high and `progEn` is low. Otherwise the word on `wrData` is discarded and the stored count does not change.
- R3: A read happens on a rising `rdClk` edge only when `rdEnA`, `rdEnB`, `oeQual` and `outReady` are all high. When any of them is low, `rdData` and `outReady` keep their values.
- R4: When a word reaches an empty FIFO, it appears on `rdData` with `outReady` high, even though no read enable is asserted.
- R5: The FIFO holds exactly DEPTH words, counting the word in the output register. After the last of them is stored, `inReady` is low, and it goes high again after a read.
- R6: While `rstN` is low, `inReady`, `outReady` and `halfFull` are low and `almostFlag` is high. After release the FIFO is empty, `inReady` goes high and the threshold returns to OFFSET_DEF.
- R7: `halfFull` is high exactly when the stored count is greater than DEPTH/2.
- R8: `almostFlag` is high exactly when the stored count is at or below the threshold, or at or above DEPTH minus the threshold.
- R9: A rising `wrClk` edge with `progEn`, `wrEnA` and `wrEnB` all high loads `wrData`, taken as an unsigned number, as the new threshold. That edge stores no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock, free running |
| rdClk | input | 1 | Read clock, free running |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnA | input | 1 | First write enable |
| wrEnB | input | 1 | Second write enable |
| progEn | input | 1 | Selects a threshold load instead of a data write |
| wrData | input | DATA_W | Write word, or threshold value while `progEn` is high |
| rdEnA | input | 1 | First read enable |
| rdEnB | input | 1 | Second read enable |
| oeQual | input | 1 | Output-enable qualifier for reads |
| rdData | output | DATA_W | Output register contents |
| inReady | output | 1 | A write will be accepted (write clock domain) |
| outReady | output | 1 | `rdData` holds a valid word (read clock domain) |
| halfFull | output | 1 | Stored count is above DEPTH/2 (write clock domain) |
| almostFlag | output | 1 | Stored count is near empty or near full (write clock domain) |

## Verification
The bench builds the block with DEPTH of 16 and OFFSET_DEF of 3, keeping the 9-bit data path. With these values, the full condition, the half-full boundary between 8 and 9 words, and both threshold edges (3 and 4 words, 12 and 13 words) are reached within a few dozen writes. The two clocks are 4 ns and 6 ns, so the Gray-coded pointers cross between truly unrelated phases. A loaded threshold of 5 gives a flag value at 5 stored words that differs from the default, so a load that fails to take effect shows up at the port.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;
  // Strobes from the control block to the datapath.
  typedef struct packed {
    logic memWrite;   // wrClk domain: store wrData at wrAddr
    logic outLoad;    // rdClk domain: move mem[rdAddr] into the output register
  } fifo_strobe_t;
endpackage

// File: rtl/ptr_sync.sv
`timescale 1ns/1ps
module ptr_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 2048,
  parameter int OFFSET_DEF  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      wrClk,
  input  logic                      rdClk,
  input  logic                      rstN,
  input  logic                      wrEnA,
  input  logic                      wrEnB,
  input  logic                      progEn,
  input  logic [DATA_W-1:0]         progValue,
  input  logic                      rdEnA,
  input  logic                      rdEnB,
  input  logic                      oeQual,
  output logic                      inReady,
  output logic                      outReady,
  output logic                      halfFull,
  output logic                      almostFlag,
  output fifo_strobe_t              ctlStb,
  output logic [$clog2(DEPTH)-1:0]  wrAddr,
  output logic [$clog2(DEPTH)-1:0]  rdAddr
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int CMP_W  = ((PTR_W > DATA_W) ? PTR_W : DATA_W) + 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] toBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write clock domain ----------------
  logic [PTR_W-1:0]  wrBin, wrGray, wrNext, freedGrayW, freedBinW, wrCount;
  logic [DATA_W-1:0] offsetQ;
  logic              runW, wrFire, progFire;
  logic [CMP_W-1:0]  cntExt, offExt;

  // freed pointer comes across from the read side
  logic [PTR_W-1:0]  freedGray;

  ptr_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_freedSync (
    .clk(wrClk), .rstN(rstN), .din(freedGray), .dout(freedGrayW)
  );

  assign freedBinW = toBin(freedGrayW);
  assign wrCount   = wrBin - freedBinW;
  assign wrNext    = wrBin + 1'b1;
  assign inReady   = runW && (wrCount != PTR_W'(DEPTH));
  assign wrFire    = wrEnA && wrEnB && !progEn && inReady;
  assign progFire  = wrEnA && wrEnB && progEn && runW;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      runW    <= 1'b0;
      offsetQ <= DATA_W'(OFFSET_DEF);
    end else begin
      runW <= 1'b1;
      if (wrFire) begin
        wrBin  <= wrNext;
        wrGray <= toGray(wrNext);
      end
      if (progFire) offsetQ <= progValue;
    end
  end

  assign cntExt     = CMP_W'(wrCount);
  assign offExt     = CMP_W'(offsetQ);
  assign halfFull   = runW && (wrCount > PTR_W'(DEPTH / 2));
  assign almostFlag = !runW || (cntExt <= offExt) || ((cntExt + offExt) >= CMP_W'(DEPTH));

  // ---------------- read clock domain ----------------
  logic [PTR_W-1:0] rdBin, freedBin, wrGrayR, wrBinR, freedNext;
  logic             outValid, memHasData, rdFire, loadOut;

  ptr_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrSync (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGrayR)
  );

  assign wrBinR     = toBin(wrGrayR);
  assign memHasData = (rdBin != wrBinR);
  assign rdFire     = rdEnA && rdEnB && oeQual && outValid;
  assign loadOut    = memHasData && (!outValid || rdFire);
  assign freedNext  = freedBin + 1'b1;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin     <= '0;
      freedBin  <= '0;
      freedGray <= '0;
      outValid  <= 1'b0;
    end else begin
      if (loadOut) rdBin <= rdBin + 1'b1;
      if (rdFire) begin
        freedBin  <= freedNext;
        freedGray <= toGray(freedNext);
      end
      if (loadOut)     outValid <= 1'b1;
      else if (rdFire) outValid <= 1'b0;
    end
  end

  assign outReady = outValid;
  assign ctlStb   = fifo_strobe_t'{memWrite: wrFire, outLoad: loadOut};
  assign wrAddr   = wrBin[ADDR_W-1:0];
  assign rdAddr   = rdBin[ADDR_W-1:0];
endmodule

// File: rtl/fifo_dpath.sv
`timescale 1ns/1ps
module fifo_dpath
  import fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  fifo_strobe_t             ctlStb,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] outWord;

  always_ff @(posedge wrClk) begin
    if (ctlStb.memWrite) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)               outWord <= '0;
    else if (ctlStb.outLoad) outWord <= mem[rdAddr];
  end

  assign rdData = outWord;
endmodule

// File: rtl/fallthru_fifo.sv
`timescale 1ns/1ps
module fallthru_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int DEPTH      = 2048,
  parameter int OFFSET_DEF = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic              wrEnB,
  input  logic              progEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnA,
  input  logic              rdEnB,
  input  logic              oeQual,
  output logic [DATA_W-1:0] rdData,
  output logic              inReady,
  output logic              outReady,
  output logic              halfFull,
  output logic              almostFlag
);
  localparam int ADDR_W = $clog2(DEPTH);

  fifo_strobe_t      ctlStb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFFSET_DEF(OFFSET_DEF), .SYNC_STAGES(2)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .progEn(progEn), .progValue(wrData),
    .rdEnA(rdEnA), .rdEnB(rdEnB), .oeQual(oeQual),
    .inReady(inReady), .outReady(outReady), .halfFull(halfFull), .almostFlag(almostFlag),
    .ctlStb(ctlStb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .ctlStb(ctlStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/fallthru_fifo_checker.sv
`timescale 1ns/1ps
module fallthru_fifo_checker
  import fifo_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEnA,
  input logic              wrEnB,
  input logic              progEn,
  input logic              rdEnA,
  input logic              rdEnB,
  input logic              oeQual,
  input logic [DATA_W-1:0] rdData,
  input logic              inReady,
  input logic              outReady,
  input logic              halfFull,
  input logic              almostFlag,
  input fifo_strobe_t      ctlStb
);
  // R2: the memory is written only for a fully qualified write
  assert_write_gated_R2: assert property (@(posedge wrClk) disable iff (!rstN)
    ctlStb.memWrite |-> (inReady && wrEnA && wrEnB && !progEn));

  // R3: without a qualified read, the output word and its flag hold
  assert_output_hold_R3: assert property (@(posedge rdClk) disable iff (!rstN)
    (outReady && !(rdEnA && rdEnB && oeQual)) |=> (outReady && $stable(rdData)));

  // R4: a load into the output register always presents a valid word
  assert_fall_through_R4: assert property (@(posedge rdClk) disable iff (!rstN)
    ctlStb.outLoad |=> outReady);

  // R5: input-ready drops only when the buffer is at full count
  assert_full_flags_R5: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(inReady) |-> (halfFull && almostFlag));

  // R6: flag levels while reset is held
  always @(posedge wrClk) begin
    if (!rstN) begin
      assert_reset_flags_R6: assert (!inReady && !outReady && !halfFull && almostFlag)
        else $error("reset flag levels wrong");
    end
  end
endmodule

bind fallthru_fifo fallthru_fifo_checker #(.DATA_W(DATA_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrEnA(wrEnA), .wrEnB(wrEnB), .progEn(progEn),
  .rdEnA(rdEnA), .rdEnB(rdEnB), .oeQual(oeQual),
  .rdData(rdData), .inReady(inReady), .outReady(outReady),
  .halfFull(halfFull), .almostFlag(almostFlag), .ctlStb(ctlStb)
);

// File: tb/fallthru_fifo_bench.sv
`timescale 1ns/1ps
module fallthru_fifo_bench;
  localparam int DATA_W     = 9;
  localparam int DEPTH      = 16;
  localparam int OFFSET_DEF = 3;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b1;
  logic wrEnA = 0, wrEnB = 0, progEn = 0, rdEnA = 0, rdEnB = 0, oeQual = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic inReady, outReady, halfFull, almostFlag;

  int nChecks = 0;
  int nFails  = 0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  always #3 rdClk = ~rdClk;

  fallthru_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFFSET_DEF(OFFSET_DEF)) u_fallthru_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnA(wrEnA), .wrEnB(wrEnB), .progEn(progEn), .wrData(wrData),
    .rdEnA(rdEnA), .rdEnB(rdEnB), .oeQual(oeQual),
    .rdData(rdData), .inReady(inReady), .outReady(outReady),
    .halfFull(halfFull), .almostFlag(almostFlag)
  );

  // stimulus words and, by R1, the expected output order
  localparam logic [DATA_W-1:0] VEC [10] = '{9'h1FF, 9'h000, 9'h155, 9'h0AA, 9'h101,
                                             9'h0FE, 9'h033, 9'h1C3, 9'h07E, 9'h180};

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rdClk);
    @(negedge wrClk);
  endtask

  task automatic pushWord(input logic [DATA_W-1:0] w);
    @(negedge wrClk);
    wrData = w; wrEnA = 1; wrEnB = 1;
    @(negedge wrClk);
    wrEnA = 0; wrEnB = 0;
  endtask

  task automatic popWord(output logic [DATA_W-1:0] w, output bit got);
    @(negedge rdClk);
    for (int k = 0; k < 40 && !outReady; k++) @(negedge rdClk);
    got = outReady;
    w   = rdData;
    rdEnA = 1; rdEnB = 1; oeQual = 1;
    @(negedge rdClk);
    rdEnA = 0; rdEnB = 0; oeQual = 0;
  endtask

  task automatic doReset();
    @(negedge wrClk);
    rstN = 0;
    repeat (6) @(negedge rdClk);
    checkEq("R6 inReady in reset", inReady, 0);
    checkEq("R6 outReady in reset", outReady, 0);
    checkEq("R6 halfFull in reset", halfFull, 0);
    checkEq("R6 almostFlag in reset", almostFlag, 1);
    @(negedge wrClk);
    rstN = 1;
    settle();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [DATA_W-1:0] w;
    bit got;
    #1;
    doReset();
    checkEq("R6 inReady after reset", inReady, 1);
    checkEq("R6 outReady after reset", outReady, 0);
    checkEq("R8 almostFlag empty", almostFlag, 1);

    // R4: fall-through without any read request
    pushWord(9'h1A5);
    settle();
    checkEq("R4 outReady fall-through", outReady, 1);
    checkEq("R4 rdData fall-through", rdData, 9'h1A5);

    // R3: partial read qualifications are ignored
    @(negedge rdClk); rdEnA = 1; rdEnB = 1; oeQual = 0;
    repeat (4) @(negedge rdClk);
    rdEnB = 0; oeQual = 1;
    repeat (4) @(negedge rdClk);
    rdEnA = 0; oeQual = 0;
    checkEq("R3 outReady held", outReady, 1);
    checkEq("R3 rdData held", rdData, 9'h1A5);
    popWord(w, got);
    settle();
    checkEq("R3 outReady after read", outReady, 0);

    // R1: vector table walked in order
    foreach (VEC[i]) pushWord(VEC[i]);
    checkEq("R7 halfFull at 10", halfFull, 1);
    checkEq("R8 almostFlag at 10", almostFlag, 0);
    foreach (VEC[i]) begin
      popWord(w, got);
      checkEq("R1 word present", got, 1);
      checkEq("R1 word order", w, VEC[i]);
    end
    settle();
    checkEq("R8 almostFlag drained", almostFlag, 1);

    // R2: write with one enable low is discarded
    @(negedge wrClk); wrData = 9'h0EE; wrEnA = 1; wrEnB = 0;
    @(negedge wrClk); wrEnA = 0;
    settle();
    checkEq("R2 single enable ignored", outReady, 0);

    // R5/R7/R8: fill to capacity with boundary checks
    for (int i = 0; i < DEPTH; i++) begin
      pushWord(DATA_W'(i));
      if (i == 2)  checkEq("R8 almostFlag at 3", almostFlag, 1);
      if (i == 3)  checkEq("R8 almostFlag at 4", almostFlag, 0);
      if (i == 7)  checkEq("R7 halfFull at 8", halfFull, 0);
      if (i == 8)  checkEq("R7 halfFull at 9", halfFull, 1);
      if (i == 11) checkEq("R8 almostFlag at 12", almostFlag, 0);
      if (i == 12) checkEq("R8 almostFlag at 13", almostFlag, 1);
    end
    checkEq("R5 inReady full", inReady, 0);
    pushWord(9'h0FF);   // dropped
    popWord(w, got);
    checkEq("R5 first word", w, 0);
    settle();
    checkEq("R5 inReady after read", inReady, 1);
    for (int i = 1; i < DEPTH; i++) begin
      popWord(w, got);
      checkEq("R5 drain order", w, i);
    end
    settle();
    checkEq("R2 write at full dropped", outReady, 0);

    // R9: load threshold 5
    @(negedge wrClk); wrData = 9'd5; progEn = 1; wrEnA = 1; wrEnB = 1;
    @(negedge wrClk); progEn = 0; wrEnA = 0; wrEnB = 0;
    settle();
    checkEq("R9 no word stored", outReady, 0);
    for (int i = 0; i < 5; i++) pushWord(DATA_W'(i + 40));
    checkEq("R9 almostFlag at 5 with threshold 5", almostFlag, 1);
    pushWord(9'd45);
    checkEq("R9 almostFlag at 6", almostFlag, 0);

    // R6: reset mid-run restores empty state and default threshold
    doReset();
    checkEq("R6 outReady empty", outReady, 0);
    checkEq("R6 inReady ready", inReady, 1);
    for (int i = 0; i < 5; i++) pushWord(DATA_W'(i + 60));
    checkEq("R6 default threshold restored", almostFlag, 0);
    popWord(w, got);
    checkEq("R6 first word after reset", w, 60);

    finishRun();
  end
endmodule